// File: doc/BRIEF.md
# Framebuffer Mode Decoder and Validator

This block turns a set of stored display mode registers into the scan-out geometry that a pixel fetcher needs. These are a pixel format code, the bytes per pixel, the line stride in bytes, the frame size in bytes and the byte offset of the first visible pixel in video memory. The inputs are the control word, the colour depth, the visible resolution, the virtual line width, the pan position, a framebuffer byte-order flag and the size of video memory. The block only accepts a mode as usable after a set of checks. Output is enabled, the depth is supported, the resolution is at least a minimum square, and the visible frame lies entirely inside video memory.

The decode is split over two register stages. The first stage decodes the format and clamps the virtual width. The second stage forms the products, runs the bounds checks and updates the output latch. The output latch keeps the last accepted mode. While the registers describe an unusable mode, `mode_valid` is low and the geometry outputs keep their previous values. A one-cycle `mode_changed` pulse marks every cycle in which a newly accepted mode differs from the latched one. A downstream consumer can use this pulse to rebuild its surface. All pins are plain level signals. The registers are sampled on every clock, so there is no handshake and no back-pressure.

Top module: `fbm_mode_decoder`

## Requirements
- R1: When bit 0 of `ctl_word` is 0, the mode is rejected and `mode_valid` is 0.
- R2: A depth code of 16 gives format code 1 (5-6-5 RGB) and 2 bytes per pixel.
- R3: A depth code of 32 gives 4 bytes per pixel. The format code is 2 (little-endian xRGB 8-8-8-8) when `fb_be` is 0, and 3 (big-endian) when `fb_be` is 1.
- R4: Any depth code other than 16 or 32 rejects the mode.
- R5: The effective line width is `virt_w`, raised to `h_res` when `virt_w` is smaller. The stride is that width times the bytes per pixel.
- R6: The frame size is stride × `v_res`. The offset is `pan_x` × bytes per pixel + `pan_y` × stride. Both are exact, with no truncation, for all 16-bit inputs.
- R7: A mode with `h_res` below 64 or `v_res` below 64 is rejected. A value of exactly 64 is accepted.
- R8: A mode whose offset + size exceeds `vram_bytes` is rejected. A sum equal to `vram_bytes` is accepted.
- R9: Register values present before clock edge k are reflected on the outputs after edge k+1. The latency is two cycles.
- R10: `mode_changed` is high for exactly one cycle when an accepted mode differs from the latched mode in format, bytes per pixel, stride, size or offset. The pulse comes in the same cycle as the new outputs. No pulse comes for a repeat of the latched mode, even after a run of rejected modes.
- R11: After reset, all outputs are 0. While `mode_valid` is 0, the geometry and format outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_word | input | REG_W | Control register; bit 0 enables output |
| bpp_code | input | REG_W | Colour depth in bits per pixel |
| h_res | input | REG_W | Visible width in pixels |
| v_res | input | REG_W | Visible height in lines |
| virt_w | input | REG_W | Virtual line width in pixels |
| pan_x | input | REG_W | Horizontal pan in pixels |
| pan_y | input | REG_W | Vertical pan in lines |
| fb_be | input | 1 | Framebuffer byte order for 32-bit pixels, 1 = big-endian |
| vram_bytes | input | MEM_W | Video memory size in bytes |
| fmt_out | output | 2 | Format code of the latched mode |
| bpp_out | output | 3 | Bytes per pixel of the latched mode |
| stride_out | output | REG_W+2 | Line stride in bytes |
| size_out | output | 2*REG_W+2 | Frame size in bytes |
| offset_out | output | 2*REG_W+3 | Start offset in bytes |
| mode_valid | output | 1 | Current registers describe a usable mode |
| mode_changed | output | 1 | One-cycle pulse when a new mode is latched |

## Verification
The decode is tried with full-size modes at both depths, and with a byte-order flip that changes nothing but the format code. It is also tried with a virtual width below, at and above the visible width, which separates the clamp from a plain copy. Width and height are stepped across 63/64. The pan is placed so that offset + size sits exactly on, and one line past, the memory size, which pins the bounds comparison to "greater than". A maximal 65535-square mode at 4 bytes per pixel exposes any product truncated below its full width. Returning to an already latched mode after rejected ones shows whether the change pulse compares against the latch rather than against the previous cycle.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  typedef enum logic [1:0] {
    FMT_NONE    = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_XRGB_LE = 2'd2,
    FMT_XRGB_BE = 2'd3
  } pix_fmt_e;
endpackage

// File: rtl/fbm_fmt_decode.sv
module fbm_fmt_decode
  import fbm_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic [REG_W-1:0] bpp_code,
  input  logic             be_flag,
  output pix_fmt_e         fmt,
  output logic [2:0]       bytes_pp,
  output logic             fmt_ok
);
  localparam logic [REG_W-1:0] DEPTH16 = REG_W'(16);
  localparam logic [REG_W-1:0] DEPTH32 = REG_W'(32);

  always_comb begin
    fmt      = FMT_NONE;
    bytes_pp = 3'd0;
    fmt_ok   = 1'b0;
    if (bpp_code == DEPTH16) begin
      fmt      = FMT_RGB565;
      bytes_pp = 3'd2;
      fmt_ok   = 1'b1;
    end else if (bpp_code == DEPTH32) begin
      fmt      = be_flag ? FMT_XRGB_BE : FMT_XRGB_LE;
      bytes_pp = 3'd4;
      fmt_ok   = 1'b1;
    end
  end
endmodule

// File: rtl/fbm_geom_calc.sv
module fbm_geom_calc #(
  parameter int REG_W = 16
) (
  input  logic [2:0]         bytes_pp,
  input  logic [REG_W-1:0]   line_w,
  input  logic [REG_W-1:0]   lines,
  input  logic [REG_W-1:0]   pan_px,
  input  logic [REG_W-1:0]   pan_ln,
  output logic [REG_W+1:0]   stride,
  output logic [2*REG_W+1:0] size,
  output logic [2*REG_W+2:0] offset
);
  localparam int STRIDE_W = REG_W + 2;
  localparam int SIZE_W   = 2 * REG_W + 2;
  localparam int OFFS_W   = 2 * REG_W + 3;

  always_comb begin
    stride = STRIDE_W'(line_w) * STRIDE_W'(bytes_pp);
    size   = SIZE_W'(stride) * SIZE_W'(lines);
    offset = OFFS_W'(pan_px) * OFFS_W'(bytes_pp) + OFFS_W'(pan_ln) * OFFS_W'(stride);
  end
endmodule

// File: rtl/fbm_bounds_check.sv
module fbm_bounds_check #(
  parameter int REG_W   = 16,
  parameter int MEM_W   = 32,
  parameter int MIN_RES = 64
) (
  input  logic               enable,
  input  logic               fmt_ok,
  input  logic [REG_W-1:0]   width,
  input  logic [REG_W-1:0]   height,
  input  logic [2*REG_W+1:0] size,
  input  logic [2*REG_W+2:0] offset,
  input  logic [MEM_W-1:0]   mem_bytes,
  output logic               usable
);
  localparam int SUM_W = 2 * REG_W + 4;
  localparam int CMP_W = (SUM_W > MEM_W) ? SUM_W : MEM_W;
  localparam logic [REG_W-1:0] MIN_V = REG_W'(MIN_RES);

  logic [CMP_W-1:0] end_byte;
  logic             fits, big_enough;

  always_comb begin
    end_byte   = CMP_W'(offset) + CMP_W'(size);
    fits       = end_byte <= CMP_W'(mem_bytes);
    big_enough = (width >= MIN_V) && (height >= MIN_V);
    usable     = enable && fmt_ok && big_enough && fits;
  end
endmodule

// File: rtl/fbm_mode_decoder.sv
module fbm_mode_decoder
  import fbm_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int MEM_W   = 32,
  parameter int MIN_RES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_W-1:0]   ctl_word,
  input  logic [REG_W-1:0]   bpp_code,
  input  logic [REG_W-1:0]   h_res,
  input  logic [REG_W-1:0]   v_res,
  input  logic [REG_W-1:0]   virt_w,
  input  logic [REG_W-1:0]   pan_x,
  input  logic [REG_W-1:0]   pan_y,
  input  logic               fb_be,
  input  logic [MEM_W-1:0]   vram_bytes,
  output logic [1:0]         fmt_out,
  output logic [2:0]         bpp_out,
  output logic [REG_W+1:0]   stride_out,
  output logic [2*REG_W+1:0] size_out,
  output logic [2*REG_W+2:0] offset_out,
  output logic               mode_valid,
  output logic               mode_changed
);
  localparam int STRIDE_W = REG_W + 2;
  localparam int SIZE_W   = 2 * REG_W + 2;
  localparam int OFFS_W   = 2 * REG_W + 3;

  // stage 1: format decode and width clamp
  pix_fmt_e         dec_fmt;
  logic [2:0]       dec_bpp;
  logic             dec_ok;
  logic [REG_W-1:0] eff_w;

  fbm_fmt_decode #(.REG_W(REG_W)) u_fmt (
    .bpp_code (bpp_code),
    .be_flag  (fb_be),
    .fmt      (dec_fmt),
    .bytes_pp (dec_bpp),
    .fmt_ok   (dec_ok)
  );

  assign eff_w = (virt_w < h_res) ? h_res : virt_w;

  logic             s1_en, s1_ok;
  pix_fmt_e         s1_fmt;
  logic [2:0]       s1_bpp;
  logic [REG_W-1:0] s1_w, s1_h, s1_line, s1_px, s1_py;
  logic [MEM_W-1:0] s1_mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_en   <= 1'b0;
      s1_ok   <= 1'b0;
      s1_fmt  <= FMT_NONE;
      s1_bpp  <= '0;
      s1_w    <= '0;
      s1_h    <= '0;
      s1_line <= '0;
      s1_px   <= '0;
      s1_py   <= '0;
      s1_mem  <= '0;
    end else begin
      s1_en   <= ctl_word[0];
      s1_ok   <= dec_ok;
      s1_fmt  <= dec_fmt;
      s1_bpp  <= dec_bpp;
      s1_w    <= h_res;
      s1_h    <= v_res;
      s1_line <= eff_w;
      s1_px   <= pan_x;
      s1_py   <= pan_y;
      s1_mem  <= vram_bytes;
    end
  end

  // stage 2: products, checks and output latch
  logic [STRIDE_W-1:0] g_stride;
  logic [SIZE_W-1:0]   g_size;
  logic [OFFS_W-1:0]   g_offset;
  logic                g_usable, g_differs;

  fbm_geom_calc #(.REG_W(REG_W)) u_geom (
    .bytes_pp (s1_bpp),
    .line_w   (s1_line),
    .lines    (s1_h),
    .pan_px   (s1_px),
    .pan_ln   (s1_py),
    .stride   (g_stride),
    .size     (g_size),
    .offset   (g_offset)
  );

  fbm_bounds_check #(.REG_W(REG_W), .MEM_W(MEM_W), .MIN_RES(MIN_RES)) u_chk (
    .enable    (s1_en),
    .fmt_ok    (s1_ok),
    .width     (s1_w),
    .height    (s1_h),
    .size      (g_size),
    .offset    (g_offset),
    .mem_bytes (s1_mem),
    .usable    (g_usable)
  );

  assign g_differs = ({s1_fmt, s1_bpp, g_stride, g_size, g_offset} !=
                      {fmt_out, bpp_out, stride_out, size_out, offset_out});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_out      <= '0;
      bpp_out      <= '0;
      stride_out   <= '0;
      size_out     <= '0;
      offset_out   <= '0;
      mode_valid   <= 1'b0;
      mode_changed <= 1'b0;
    end else begin
      mode_valid   <= g_usable;
      mode_changed <= g_usable && g_differs;
      if (g_usable && g_differs) begin
        fmt_out    <= s1_fmt;
        bpp_out    <= s1_bpp;
        stride_out <= g_stride;
        size_out   <= g_size;
        offset_out <= g_offset;
      end
    end
  end

  // R10: a change pulse only accompanies an accepted mode
  assert_pulse_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> mode_valid);

  // R10/R11: latched geometry moves only together with a pulse
  assert_latch_moves_on_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_changed |-> ($stable(fmt_out) && $stable(bpp_out) && $stable(stride_out)
                       && $stable(size_out) && $stable(offset_out)));

  // R10: a pulse always carries a geometry different from the one before
  assert_pulse_is_new_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> !($stable(fmt_out) && $stable(bpp_out) && $stable(stride_out)
                       && $stable(size_out) && $stable(offset_out)));

  // R2/R3: format code and pixel size stay paired
  assert_fmt_pairing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> ((fmt_out == 2'd1 && bpp_out == 3'd2) ||
                    (fmt_out[1] && bpp_out == 3'd4)));

  // R7: an accepted mode's stride covers at least the minimum width
  assert_min_stride_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> (stride_out >= STRIDE_W'(2 * MIN_RES)));
endmodule

// File: tb/fbm_mode_decoder_test.sv
`timescale 1ns/1ps
module fbm_mode_decoder_test;
  localparam int REG_W = 16;
  localparam int MEM_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [REG_W-1:0] ctl_word = '0, bpp_code = '0, h_res = '0, v_res = '0;
  logic [REG_W-1:0] virt_w = '0, pan_x = '0, pan_y = '0;
  logic fb_be = 1'b0;
  logic [MEM_W-1:0] vram_bytes = '0;
  logic [1:0] fmt_out;
  logic [2:0] bpp_out;
  logic [REG_W+1:0] stride_out;
  logic [2*REG_W+1:0] size_out;
  logic [2*REG_W+2:0] offset_out;
  logic mode_valid, mode_changed;

  always #2.5 clk = ~clk;

  fbm_mode_decoder #(.REG_W(REG_W), .MEM_W(MEM_W), .MIN_RES(64)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .bpp_code(bpp_code),
    .h_res(h_res), .v_res(v_res), .virt_w(virt_w), .pan_x(pan_x), .pan_y(pan_y),
    .fb_be(fb_be), .vram_bytes(vram_bytes), .fmt_out(fmt_out), .bpp_out(bpp_out),
    .stride_out(stride_out), .size_out(size_out), .offset_out(offset_out),
    .mode_valid(mode_valid), .mode_changed(mode_changed)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R11";

  // reference model: behavioural, one register of delay per stage
  longint d_en, d_bpp, d_w, d_h, d_vw, d_px, d_py, d_be, d_mem;
  longint m_fmt, m_bpp, m_stride, m_size, m_off;
  bit m_valid, m_chg;
  longint t_fmt, t_bpp, t_line, t_stride, t_size, t_off;
  bit t_ok;

  always @(posedge clk) begin
    if (!rst_n) begin
      {d_en, d_bpp, d_w, d_h, d_vw, d_px, d_py, d_be, d_mem} = '0;
      {m_fmt, m_bpp, m_stride, m_size, m_off} = '0;
      m_valid = 0; m_chg = 0;
    end else begin
      t_ok = (d_en != 0);
      if (d_bpp == 16) begin t_fmt = 1; t_bpp = 2; end
      else if (d_bpp == 32) begin t_fmt = d_be ? 3 : 2; t_bpp = 4; end
      else begin t_fmt = 0; t_bpp = 0; t_ok = 0; end
      t_line   = (d_vw < d_w) ? d_w : d_vw;
      t_stride = t_line * t_bpp;
      t_size   = t_stride * d_h;
      t_off    = d_px * t_bpp + d_py * t_stride;
      if (d_w < 64 || d_h < 64) t_ok = 0;
      if (t_off + t_size > d_mem) t_ok = 0;
      m_valid = t_ok;
      m_chg = 0;
      if (t_ok && (t_fmt != m_fmt || t_bpp != m_bpp || t_stride != m_stride ||
                   t_size != m_size || t_off != m_off)) begin
        m_chg = 1;
        m_fmt = t_fmt; m_bpp = t_bpp; m_stride = t_stride; m_size = t_size; m_off = t_off;
      end
      d_en = ctl_word[0]; d_bpp = bpp_code; d_w = h_res; d_h = v_res; d_vw = virt_w;
      d_px = pan_x; d_py = pan_y; d_be = fb_be; d_mem = vram_bytes;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (mode_valid !== m_valid || mode_changed !== m_chg || fmt_out !== m_fmt[1:0] ||
          bpp_out !== m_bpp[2:0] || stride_out !== m_stride[REG_W+1:0] ||
          size_out !== m_size[2*REG_W+1:0] || offset_out !== m_off[2*REG_W+2:0]) begin
        errors++;
        $display("FAIL %s t=%0t: got v=%0b c=%0b fmt=%0d bpp=%0d stride=%0d size=%0d off=%0d; exp v=%0b c=%0b fmt=%0d bpp=%0d stride=%0d size=%0d off=%0d",
                 cur_req, $time, mode_valid, mode_changed, fmt_out, bpp_out, stride_out,
                 size_out, offset_out, m_valid, m_chg, m_fmt, m_bpp, m_stride, m_size, m_off);
      end
    end
  end

  task automatic apply(input string tag, input logic en, input int bpp, input int w,
                       input int h, input int vw, input int px, input int py,
                       input logic be, input longint mem, input int cyc);
    @(negedge clk);
    cur_req = tag;
    ctl_word = {15'd0, en}; bpp_code = bpp[15:0]; h_res = w[15:0]; v_res = h[15:0];
    virt_w = vw[15:0]; pan_x = px[15:0]; pan_y = py[15:0]; fb_be = be;
    vram_bytes = mem[31:0];
    repeat (cyc) @(negedge clk);
  endtask

  localparam longint MEM16M = 64'd16777216;

  initial begin
    cur_req = "R11";                        // reset state: all zero
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    apply("R3", 1, 32, 640, 480, 0, 0, 0, 0, MEM16M, 5);       // R3 LE, R9 latency, R10 pulse
    apply("R10", 1, 32, 640, 480, 0, 0, 0, 0, MEM16M, 4);      // same mode, no pulse
    apply("R3", 1, 32, 640, 480, 0, 0, 0, 1, MEM16M, 4);       // R3 BE flips format only
    apply("R2", 1, 16, 800, 600, 1024, 8, 10, 0, MEM16M, 4);   // R2, R5 wide virtual, R6 pan
    apply("R5", 1, 16, 800, 600, 800, 3, 2, 0, MEM16M, 4);     // R5 equal width
    apply("R5", 1, 16, 800, 600, 100, 3, 2, 0, MEM16M, 4);     // R5 clamp up, same as above
    apply("R6", 1, 32, 1024, 768, 1280, 17, 33, 0, MEM16M, 4); // R6 offset math
    for (int b = 0; b < 40; b += 7)                           // R4 unsupported depths, R11 hold
      apply("R4", 1, b + 1, 640, 480, 0, 0, 0, 0, MEM16M, 3);
    apply("R4", 1, 24, 640, 480, 0, 0, 0, 0, MEM16M, 3);
    apply("R11", 1, 32, 1024, 768, 1280, 17, 33, 0, MEM16M, 4); // return to latched, no pulse
    apply("R1", 0, 32, 640, 480, 0, 0, 0, 0, MEM16M, 4);       // R1 disabled
    apply("R7", 1, 32, 63, 200, 0, 0, 0, 0, MEM16M, 3);        // R7 width 63
    apply("R7", 1, 32, 64, 200, 0, 0, 0, 0, MEM16M, 3);        // R7 width 64
    apply("R7", 1, 32, 200, 63, 0, 0, 0, 0, MEM16M, 3);        // R7 height 63
    apply("R7", 1, 32, 64, 64, 64, 0, 0, 0, MEM16M, 3);        // R7 64 square
    apply("R8", 1, 32, 64, 64, 64, 0, 65472, 0, MEM16M, 4);    // R8 ends exactly at memory end
    apply("R8", 1, 32, 64, 64, 64, 0, 65473, 0, MEM16M, 4);    // R8 one line past
    apply("R8", 1, 32, 64, 64, 64, 1, 65472, 0, MEM16M, 4);    // R8 four bytes past
    apply("R6", 1, 32, 65535, 65535, 65535, 65535, 65535, 0, 64'hFFFF_FFFF, 4); // R6 wide, R8 reject
    apply("R6", 1, 16, 2000, 2000, 4000, 100, 100, 0, 64'hFFFF_FFFF, 4);       // R6 large accept
    apply("R9", 1, 16, 64, 64, 0, 0, 0, 0, MEM16M, 1);        // R9 short pulse of settings
    apply("R9", 1, 32, 128, 128, 0, 0, 0, 0, MEM16M, 1);
    apply("R9", 1, 16, 96, 96, 0, 0, 0, 0, MEM16M, 4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule